// File: doc/BRIEF.md
# Banked 4K-Node Memory Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and a 20-bit (1 MiB) system bus. A 4-bit bank register picks which of sixteen 64K banks the CPU currently sees. Every CPU access is translated through a 256-entry node table. The table is indexed by the active bank together with CPU address bits 15:12. Each entry gives an 8-bit physical node number and three flags: write-protect, RAM-present and valid. The physical address is the node number followed by the low twelve CPU address bits.

Zero page and the stack cover CPU addresses 0x0000 to 0x01FF. When the entry for those addresses says the node has no RAM, the access skips the table and goes to shadow RAM at the bottom of bank 0. A write to a protected node, or any access to an invalid node, is blocked. The first such access raises a sticky fault flag and records its 20-bit system address. The CPU programs the block through a small byte-wide register port. A new bank value takes effect after a fixed two-cycle delay.

Top module: `bank_mapper`

## Requirements
- R1: After reset the active bank is 0 and every entry i holds node i with valid=1, RAM-present=1 and write-protect=0. An access to CPU address A therefore reaches physical address {4'h0, A}.
- R2: For an access that is not redirected, `phys_addr` = {entry.node, cpu_addr[11:0]}.
- R3: The entry used is the one at index {active bank, cpu_addr[15:12]}.
- R4: A bank value written at config offset 0 during cycle c is used for translation from cycle c+2 on. In cycle c+1 the previous bank value is still used.
- R5: A write at offset 2 only loads a holding byte. The entry selected by the index register (offset 1) changes only when offset 3 is written, and then all 16 bits change together as {high, held low}. Entry bit layout: [7:0] node, [8] write-protect, [9] RAM-present, [10] valid, [15:11] spare.
- R6: Redirection applies when cpu_addr is below 0x0200 and the selected entry has RAM-present=0. Then `phys_addr` = {8'h00, cpu_addr[11:0]} and `shadow_hit` is 1. Write-protect and valid are not checked, so the access goes through.
- R7: A write to an entry with write-protect=1 keeps `mem_wr` low and raises `fault`. A read of that entry still goes through with `mem_rd` high.
- R8: Any access to an entry with valid=0 keeps both `mem_wr` and `mem_rd` low and raises `fault`.
- R9: `fault` rises at the clock edge after a blocked access and then stays set. `fault_addr` holds {active bank, cpu_addr} of the first blocked access and does not change on later blocked accesses. A write to offset 4 clears `fault`.
- R10: An access that is not blocked drives `mem_wr` (write) or `mem_rd` (read) for as long as `cpu_valid` is high. The two strobes are never high together.
- R11: `cfg_rdata` returns combinationally:
  - offset 0: the last bank value written;
  - offset 1: the index register;
  - offsets 2 and 3: the low and high byte of the indexed entry;
  - offset 4: {7'b0, fault}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU access in progress |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 16 | CPU address |
| cfg_we | input | 1 | Config register write strobe |
| cfg_addr | input | 3 | Config register offset |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Config read data |
| phys_addr | output | 20 | Translated system address |
| mem_rd | output | 1 | Gated read strobe |
| mem_wr | output | 1 | Gated write strobe |
| shadow_hit | output | 1 | Access redirected to bank-0 shadow RAM |
| fault | output | 1 | Sticky protection fault |
| fault_addr | output | 20 | System address of first blocked access |

## Verification
The bench samples translation in the cycle right after a bank write and again one cycle later. A design with the wrong delay would show the new bank too early or keep the old one too long. It writes the low entry byte alone and checks that both the readback and the translation are unchanged, which catches a table updated on the low byte. Shadow redirection is tried at 0x01FF and 0x0200, on a protected node with no RAM, and on a bank that has RAM, so an off-by-one page limit or a missing protection bypass shows up. Two blocked accesses in a row confirm that the recorded address belongs to the first; a design that overwrites it would report the second.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int BANK_W   = 4;
  localparam int CPU_AW   = 16;
  localparam int OFF_W    = 12;
  localparam int NODE_W   = 8;
  localparam int IDX_W    = BANK_W + (CPU_AW - OFF_W);
  localparam int ENTRIES  = 1 << IDX_W;
  localparam int PA_W     = NODE_W + OFF_W;
  localparam int SYS_W    = BANK_W + CPU_AW;
  localparam int LOWPG_HI = 9;  // addresses below 1 << LOWPG_HI are zero page + stack

  localparam logic [2:0] CFG_BANK  = 3'd0;
  localparam logic [2:0] CFG_INDEX = 3'd1;
  localparam logic [2:0] CFG_LO    = 3'd2;
  localparam logic [2:0] CFG_HI    = 3'd3;
  localparam logic [2:0] CFG_FCLR  = 3'd4;

  typedef struct packed {
    logic [4:0]        spare;
    logic              valid;
    logic              ram;
    logic              wp;
    logic [NODE_W-1:0] node;
  } node_entry_t;

  function automatic node_entry_t reset_entry(input logic [IDX_W-1:0] i);
    node_entry_t e;
    e.spare = '0;
    e.valid = 1'b1;
    e.ram   = 1'b1;
    e.wp    = 1'b0;
    e.node  = i;
    return e;
  endfunction

  function automatic logic [IDX_W-1:0] node_index(input logic [BANK_W-1:0] bank,
                                                   input logic [CPU_AW-1:0] a);
    return {bank, a[CPU_AW-1:OFF_W]};
  endfunction

  function automatic logic [PA_W-1:0] map_phys(input logic [NODE_W-1:0] node,
                                                input logic [CPU_AW-1:0] a);
    return {node, a[OFF_W-1:0]};
  endfunction

  function automatic logic in_low_pages(input logic [CPU_AW-1:0] a);
    return a[CPU_AW-1:LOWPG_HI] == '0;
  endfunction
endpackage

// File: rtl/mmu_cfg_regs.sv
module mmu_cfg_regs
  import bank_mapper_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_addr,
  input  logic [7:0]          cfg_wdata,
  output logic [BANK_W-1:0]   bank_staged,
  output logic [BANK_W-1:0]   bank_active,
  output logic [IDX_W-1:0]    index_q,
  output logic                commit,
  output node_entry_t         commit_data,
  output logic                fault_clr
);
  logic [7:0] lo_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_staged <= '0;
      bank_active <= '0;
      index_q     <= '0;
      lo_hold     <= '0;
    end else begin
      bank_active <= bank_staged;
      if (cfg_we && cfg_addr == CFG_BANK)  bank_staged <= cfg_wdata[BANK_W-1:0];
      if (cfg_we && cfg_addr == CFG_INDEX) index_q     <= cfg_wdata[IDX_W-1:0];
      if (cfg_we && cfg_addr == CFG_LO)    lo_hold     <= cfg_wdata;
    end
  end

  assign commit      = cfg_we && (cfg_addr == CFG_HI);
  assign commit_data = node_entry_t'({cfg_wdata, lo_hold});
  assign fault_clr   = cfg_we && (cfg_addr == CFG_FCLR);
endmodule

// File: rtl/mmu_node_table.sv
module mmu_node_table
  import bank_mapper_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  node_entry_t      wr_data,
  input  logic [IDX_W-1:0] xl_idx,
  output node_entry_t      xl_entry,
  input  logic [IDX_W-1:0] cfg_idx,
  output node_entry_t      cfg_entry
);
  node_entry_t mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= reset_entry(i[IDX_W-1:0]);
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign xl_entry  = mem[xl_idx];
  assign cfg_entry = mem[cfg_idx];
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import bank_mapper_pkg::*;
(
  input  logic [BANK_W-1:0] bank,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  node_entry_t       entry,
  output logic [IDX_W-1:0]  idx,
  output logic [PA_W-1:0]   phys,
  output logic [SYS_W-1:0]  sys_addr,
  output logic              shadow,
  output logic              blocked,
  output logic              rd_ok,
  output logic              wr_ok
);
  logic deny;

  always_comb begin
    idx      = node_index(bank, cpu_addr);
    sys_addr = {bank, cpu_addr};
    shadow   = in_low_pages(cpu_addr) && !entry.ram;
    phys     = shadow ? map_phys('0, cpu_addr) : map_phys(entry.node, cpu_addr);
    deny     = !shadow && (!entry.valid || (cpu_we && entry.wp));
    blocked  = cpu_valid && deny;
    rd_ok    = cpu_valid && !cpu_we && !deny;
    wr_ok    = cpu_valid &&  cpu_we && !deny;
  end
endmodule

// File: rtl/mmu_fault_log.sv
module mmu_fault_log
  import bank_mapper_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blocked,
  input  logic             clr,
  input  logic [SYS_W-1:0] sys_addr,
  output logic             fault,
  output logic [SYS_W-1:0] fault_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault      <= 1'b0;
      fault_addr <= '0;
    end else if (blocked && (!fault || clr)) begin
      fault      <= 1'b1;
      fault_addr <= sys_addr;
    end else if (clr) begin
      fault      <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic [PA_W-1:0]   phys_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              shadow_hit,
  output logic              fault,
  output logic [SYS_W-1:0]  fault_addr
);
  logic [BANK_W-1:0] bank_staged, bank_active;
  logic [IDX_W-1:0]  index_q, xl_idx;
  logic              commit, fault_clr_evt, blocked_evt;
  node_entry_t       commit_data, xl_entry, cfg_entry;
  logic [SYS_W-1:0]  sys_addr;

  mmu_cfg_regs u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .bank_staged, .bank_active, .index_q,
    .commit, .commit_data, .fault_clr(fault_clr_evt)
  );

  mmu_node_table u_table (
    .clk, .rst_n,
    .wr_en(commit), .wr_idx(index_q), .wr_data(commit_data),
    .xl_idx, .xl_entry,
    .cfg_idx(index_q), .cfg_entry
  );

  mmu_xlate u_xlate (
    .bank(bank_active), .cpu_addr, .cpu_valid, .cpu_we,
    .entry(xl_entry), .idx(xl_idx), .phys(phys_addr), .sys_addr,
    .shadow(shadow_hit), .blocked(blocked_evt),
    .rd_ok(mem_rd), .wr_ok(mem_wr)
  );

  mmu_fault_log u_flog (
    .clk, .rst_n, .blocked(blocked_evt), .clr(fault_clr_evt),
    .sys_addr, .fault, .fault_addr
  );

  always_comb begin
    unique case (cfg_addr)
      CFG_BANK:  cfg_rdata = {{(8-BANK_W){1'b0}}, bank_staged};
      CFG_INDEX: cfg_rdata = index_q;
      CFG_LO:    cfg_rdata = cfg_entry[7:0];
      CFG_HI:    cfg_rdata = cfg_entry[15:8];
      CFG_FCLR:  cfg_rdata = {7'b0, fault};
      default:   cfg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/bank_mapper_sva.sv
module bank_mapper_sva
  import bank_mapper_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_we,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              shadow_hit,
  input logic [PA_W-1:0]   phys_addr,
  input logic              fault,
  input logic [SYS_W-1:0]  fault_addr,
  input logic [SYS_W-1:0]  sys_addr,
  input logic              blocked_evt,
  input logic              fault_clr_evt,
  input logic [BANK_W-1:0] bank_staged,
  input logic [BANK_W-1:0] bank_active
);
  assert_strobe_needs_cpu_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> cpu_valid);

  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd, mem_wr}) <= 1);

  assert_wr_only_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> cpu_we);

  assert_block_raises_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_evt |=> fault);

  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_clr_evt) |=> (fault && $stable(fault_addr)));

  assert_first_addr_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked_evt && !fault) |=> (fault_addr == $past(sys_addr)));

  assert_shadow_low_phys_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_hit |-> (phys_addr[PA_W-1:OFF_W] == '0 && !blocked_evt));

  assert_bank_from_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_active != $past(bank_active)) |-> (bank_active == $past(bank_staged)));
endmodule

bind bank_mapper bank_mapper_sva u_sva (.*);

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [19:0] phys_addr, fault_addr;
  logic        mem_rd, mem_wr, shadow_hit, fault;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bank_mapper u_bank_mapper (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [7:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic set_bank(input logic [3:0] b);
    cfg_write(3'd0, {4'h0, b});
    @(negedge clk);
  endtask

  task automatic set_entry(input logic [7:0] idx, input logic [7:0] lo, input logic [7:0] hi);
    cfg_write(3'd1, idx); cfg_write(3'd2, lo); cfg_write(3'd3, hi);
  endtask

  task automatic acc_begin(input logic [15:0] a, input logic we);
    @(negedge clk); cpu_valid = 1'b1; cpu_addr = a; cpu_we = we; #1;
  endtask

  task automatic acc_end();
    @(negedge clk); cpu_valid = 1'b0; cpu_we = 1'b0; #1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1", "fault after reset", fault, 0);
    cfg_read(3'd0, d); chk("R11", "bank readback", d, 8'h00);
    acc_begin(16'h1234, 1'b0);
    chk("R1", "identity phys", phys_addr, 20'h01234);
    chk("R10", "read strobe", mem_rd, 1);
    chk("R10", "no write strobe", mem_wr, 0);
    acc_end();
    cfg_write(3'd1, 8'h37);
    cfg_read(3'd1, d); chk("R11", "index readback", d, 8'h37);
    cfg_read(3'd2, d); chk("R1", "entry low", d, 8'h37);
    cfg_read(3'd3, d); chk("R1", "entry high", d, 8'h06);
  endtask

  task automatic t_bank_select();
    set_bank(4'h5);
    acc_begin(16'hA123, 1'b1);
    chk("R3", "bank5 nibble A", phys_addr, 20'h5A123);
    chk("R10", "write strobe", mem_wr, 1);
    acc_end();
  endtask

  task automatic t_bank_delay();
    cfg_write(3'd0, 8'h09);
    cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h7001; #1;
    chk("R4", "old bank one cycle after write", phys_addr, 20'h57001);
    @(negedge clk); #1;
    chk("R4", "new bank two cycles after write", phys_addr, 20'h97001);
    cpu_valid = 1'b0;
  endtask

  task automatic t_remap();
    logic [7:0] d;
    cfg_write(3'd1, 8'h93);
    cfg_write(3'd2, 8'hC4);
    cfg_read(3'd2, d); chk("R5", "low write alone no readback change", d, 8'h93);
    acc_begin(16'h3ABC, 1'b0);
    chk("R5", "low write alone no translate change", phys_addr, 20'h93ABC);
    acc_end();
    cfg_write(3'd3, 8'h06);
    cfg_read(3'd2, d); chk("R5", "committed low", d, 8'hC4);
    acc_begin(16'h3ABC, 1'b0);
    chk("R2", "remapped phys", phys_addr, 20'hC4ABC);
    acc_end();
  endtask

  task automatic t_protect();
    logic [7:0] d;
    set_entry(8'h94, 8'h22, 8'h07);
    acc_begin(16'h4010, 1'b1);
    chk("R7", "protected write blocked", mem_wr, 0);
    acc_end();
    chk("R9", "fault raised", fault, 1);
    chk("R9", "fault addr", fault_addr, 20'h94010);
    acc_begin(16'h4010, 1'b0);
    chk("R7", "protected read allowed", mem_rd, 1);
    chk("R2", "protected read phys", phys_addr, 20'h22010);
    acc_end();
    acc_begin(16'h4FFF, 1'b1);
    acc_end();
    chk("R9", "first fault addr kept", fault_addr, 20'h94010);
    cfg_read(3'd4, d); chk("R11", "fault readback", d, 8'h01);
    cfg_write(3'd4, 8'h00); #1;
    chk("R9", "fault cleared", fault, 0);
  endtask

  task automatic t_invalid();
    set_entry(8'h95, 8'h55, 8'h02);
    acc_begin(16'h5000, 1'b0);
    chk("R8", "invalid read blocked", mem_rd, 0);
    acc_end();
    acc_begin(16'h5001, 1'b1);
    chk("R8", "invalid write blocked", mem_wr, 0);
    acc_end();
    chk("R9", "fault addr invalid", fault_addr, 20'h95000);
    cfg_write(3'd4, 8'h00); #1;
    chk("R9", "cleared again", fault, 0);
  endtask

  task automatic t_shadow();
    acc_begin(16'h0042, 1'b1);
    chk("R6", "ram bank no redirect", phys_addr, 20'h90042);
    chk("R6", "ram bank shadow flag", shadow_hit, 0);
    acc_end();
    set_entry(8'h90, 8'h77, 8'h04);
    acc_begin(16'h0042, 1'b1);
    chk("R6", "zero page redirected", phys_addr, 20'h00042);
    chk("R6", "shadow flag", shadow_hit, 1);
    acc_end();
    acc_begin(16'h01FF, 1'b0);
    chk("R6", "stack top redirected", phys_addr, 20'h001FF);
    acc_end();
    acc_begin(16'h0200, 1'b0);
    chk("R6", "above stack not redirected", phys_addr, 20'h77200);
    chk("R6", "above stack flag", shadow_hit, 0);
    acc_end();
    set_entry(8'h90, 8'h77, 8'h05);
    acc_begin(16'h0150, 1'b1);
    chk("R6", "shadow ignores write protect", mem_wr, 1);
    acc_end();
    chk("R6", "no fault on shadow", fault, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_bank_select();
    t_bank_delay();
    t_remap();
    t_protect();
    t_invalid();
    t_shadow();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule